// File: doc/BRIEF.md
# DMA Access Port for Tightly Coupled Data RAM

This block lets an external DMA requester read and write a processor's local data RAM. The requester presents a byte address, a direction, a write size and write data, and holds an active-low request while the port is enabled. The port turns each accepted request into one RAM cycle on a word-addressed RAM with per-byte write enables. Byte and halfword writes land on the byte lanes chosen by the low address bits. Reads always fetch a full word, which is then held on the read-data output.

The RAM arrangement is fixed when the block is built. When the RAM has a single port shared with the core, the requester must first raise its wait line. The port then asks the core to stall and waits for the core to report that it has halted. Only then does it signal ready and accept transfers. When the RAM has a second port reserved for DMA, the port is ready as soon as reset ends, never stalls the core and ignores the wait line.

Top module: `dma_dram_port`

## Requirements
- R1: While reset is high, and at the first clock edge after it, the RAM enable, byte enables, ready, core stall and read data are all zero.
- R2: A request is accepted at a clock edge where the request input is low, the enable input is high and ready is high. The RAM enable is then high for exactly the following cycle, with the RAM word address equal to the byte address with its two low bits dropped.
- R3: While the enable input is low, no request reaches the RAM and the RAM contents do not change.
- R4: In single-port mode, the core stall output follows the wait input one edge later. Ready rises only at an edge where wait, stall and the core's halted input are all high, so it first appears three edges after wait rises. Stall and ready both drop at the first edge after wait falls.
- R5: In single-port mode, a request made while ready is low is ignored: no RAM cycle occurs.
- R6: In dual-port mode, ready is high from the first edge after reset and the core stall output never rises, whatever the wait input does.
- R7: A write with size code 00 (byte) drives only byte enable 1<<addr[1:0]. The low data byte is copied onto all four lanes. Byte enable bit k covers data bits 8k+7:8k.
- R8: A write with size code 01 (halfword) drives byte enables 0011 when addr[1] is 0 and 1100 when addr[1] is 1, with addr[0] ignored. The low data halfword is copied onto both halves.
- R9: A write with size code 10 (word) drives all four byte enables and passes the write data unchanged.
- R10: A write with the reserved size code 11 produces no RAM cycle and leaves memory unchanged.
- R11: A read (write-select 0) drives the RAM enable with all byte enables low, whatever the size code. The RAM returns data in the cycle after its enable. The port registers that word at the next edge and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req_n | input | 1 | Active-low transfer request |
| dma_write | input | 1 | 1 = write, 0 = read |
| dma_addr | input | ADDR_W (26) | Byte address |
| dma_size | input | 2 | Write size: 00 byte, 01 halfword, 10 word, 11 reserved |
| dma_wdata | input | DATA_W (32) | Write data, right-aligned |
| dma_en | input | 1 | Port enable; no transfer while low |
| dma_wait | input | 1 | Requests a core stall (single-port mode only) |
| core_halted | input | 1 | Core reports it is stalled |
| dma_rdata | output | DATA_W (32) | Registered read data, held between reads |
| dma_ready | output | 1 | Port accepts requests |
| core_stall | output | 1 | Stall request to the core |
| ram_addr | output | ADDR_W-2 (24) | RAM word address |
| ram_en | output | 1 | RAM cycle enable |
| ram_wdata | output | DATA_W (32) | RAM write data, lane-replicated |
| ram_be | output | DATA_W/8 (4) | RAM byte write enables |
| ram_rdata | input | DATA_W (32) | RAM read data, valid the cycle after ram_en |

## Verification
A single-port and a dual-port instance receive the same stimulus, and each drives its own RAM model. Directed cases cover every byte offset, both halfword halves (including an odd address, to show addr[0] is ignored), the reserved size and a disabled port. A request made before the stall handshake finishes separates the two modes: only the dual-port instance accepts it. Seeded random mixes of reads and writes of every size are then compared against a shadow memory. That comparison would expose a wrong lane, a wrong replication or a lost merge.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } dma_size_e;
endpackage

// File: rtl/dma_handshake.sv
module dma_handshake #(
  parameter bit DUAL_PORT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic dma_wait,
  input  logic core_halted,
  output logic core_stall,
  output logic dma_ready
);
  generate
    if (DUAL_PORT) begin : g_dual
      // Second RAM port: no arbitration with the core is needed.
      logic rdy_q;
      always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= 1'b1;
      end
      assign core_stall = 1'b0;
      assign dma_ready  = rdy_q;
      logic unused_in;
      assign unused_in = dma_wait ^ core_halted;
    end else begin : g_single
      logic stall_q, rdy_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stall_q <= 1'b0;
          rdy_q   <= 1'b0;
        end else begin
          stall_q <= dma_wait;
          rdy_q   <= dma_wait & stall_q & core_halted;
        end
      end
      assign core_stall = stall_q;
      assign dma_ready  = rdy_q;
    end
  endgenerate
endmodule

// File: rtl/dma_lane_map.sv
module dma_lane_map
  import dma_port_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data,
  output logic              size_ok
);
  dma_size_e sz;
  assign sz      = dma_size_e'(size);
  assign size_ok = (sz != SZ_RSVD);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic       be_l;
      logic [7:0] d_l;
      always_comb begin
        case (sz)
          SZ_BYTE: begin
            be_l = (off == OFF_W'(i));
            d_l  = wdata[7:0];
          end
          SZ_HALF: begin
            be_l = ((off >> 1) == OFF_W'(i >> 1));
            d_l  = wdata[8*(i%2) +: 8];
          end
          SZ_WORD: begin
            be_l = 1'b1;
            d_l  = wdata[8*i +: 8];
          end
          default: begin
            be_l = 1'b0;
            d_l  = 8'h00;
          end
        endcase
      end
      assign be[i]            = be_l;
      assign lane_data[8*i +: 8] = d_l;
    end
  endgenerate
endmodule

// File: rtl/dma_rd_capture.sv
module dma_rd_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic cap_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      rdata <= '0;
    end else begin
      cap_q <= rd_issue;
      if (cap_q) rdata <= ram_rdata;
    end
  end
endmodule

// File: rtl/dma_dram_port.sv
module dma_dram_port #(
  parameter bit DUAL_PORT = 1'b0,
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 32,
  localparam int LANES    = DATA_W / 8,
  localparam int OFF_W    = $clog2(LANES),
  localparam int RAM_AW   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_req_n,
  input  logic              dma_write,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [1:0]        dma_size,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              dma_en,
  input  logic              dma_wait,
  input  logic              core_halted,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_ready,
  output logic              core_stall,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_en,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [LANES-1:0]  ram_be,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic [LANES-1:0]  map_be;
  logic [DATA_W-1:0] map_data;
  logic              size_ok;
  logic              accept;
  logic              rd_q;

  dma_handshake #(.DUAL_PORT(DUAL_PORT)) u_hs (
    .clk(clk), .rst(rst), .dma_wait(dma_wait), .core_halted(core_halted),
    .core_stall(core_stall), .dma_ready(dma_ready)
  );

  dma_lane_map #(.DATA_W(DATA_W)) u_map (
    .size(dma_size), .off(dma_addr[OFF_W-1:0]), .wdata(dma_wdata),
    .be(map_be), .lane_data(map_data), .size_ok(size_ok)
  );

  assign accept = !dma_req_n && dma_en && dma_ready && (!dma_write || size_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_en    <= 1'b0;
      ram_addr  <= '0;
      ram_be    <= '0;
      ram_wdata <= '0;
      rd_q      <= 1'b0;
    end else begin
      ram_en <= accept;
      rd_q   <= accept && !dma_write;
      ram_be <= (accept && dma_write) ? map_be : '0;
      if (accept) begin
        ram_addr  <= dma_addr[ADDR_W-1:OFF_W];
        ram_wdata <= dma_write ? map_data : '0;
      end
    end
  end

  dma_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .rd_issue(rd_q), .ram_rdata(ram_rdata), .rdata(dma_rdata)
  );
endmodule

// File: rtl/dma_dram_port_chk.sv
module dma_dram_port_chk #(
  parameter bit DUAL_PORT = 1'b0,
  parameter int DATA_W    = 32,
  localparam int LANES    = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dma_req_n,
  input logic              dma_write,
  input logic [1:0]        dma_size,
  input logic              dma_en,
  input logic              core_halted,
  input logic              dma_ready,
  input logic              core_stall,
  input logic              ram_en,
  input logic [LANES-1:0]  ram_be,
  input logic [DATA_W-1:0] dma_rdata
);
  assert_access_needs_grant_R2: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> $past(!dma_req_n && dma_en && dma_ready));

  assert_disabled_no_access_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(dma_en) |-> !ram_en);

  assert_ready_needs_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (!DUAL_PORT && dma_ready) |-> (core_stall && $past(core_halted)));

  assert_dual_never_stalls_R6: assert property (@(posedge clk) disable iff (rst)
    DUAL_PORT |-> !core_stall);

  assert_write_lane_count_R7: assert property (@(posedge clk) disable iff (rst)
    (ram_en && ram_be != '0) |->
      ($countones(ram_be) == 1 || $countones(ram_be) == 2 || $countones(ram_be) == LANES));

  assert_reserved_no_access_R10: assert property (@(posedge clk) disable iff (rst)
    $past(dma_write && dma_size == 2'b11) |-> !ram_en);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !($past(ram_en, 2) && $past(ram_be, 2) == '0) |-> $stable(dma_rdata));
endmodule

bind dma_dram_port dma_dram_port_chk #(.DUAL_PORT(DUAL_PORT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .dma_req_n(dma_req_n), .dma_write(dma_write),
  .dma_size(dma_size), .dma_en(dma_en), .core_halted(core_halted),
  .dma_ready(dma_ready), .core_stall(core_stall), .ram_en(ram_en),
  .ram_be(ram_be), .dma_rdata(dma_rdata)
);

// File: tb/test_dma_dram_port.sv
module test_dma_dram_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_n = 1'b1, wr = 1'b0, en = 1'b1, dwait = 1'b0;
  logic [25:0] addr = '0;
  logic [1:0]  size = 2'b10;
  logic [31:0] wd = '0;
  logic        halted = 1'b0;

  logic [31:0] rd_s, rd_d, rwd_s, rwd_d, rrd_s, rrd_d;
  logic        rdy_s, rdy_d, stl_s, stl_d, ren_s, ren_d;
  logic [23:0] ra_s, ra_d;
  logic [3:0]  be_s, be_d;

  logic [31:0] mem_s [256];
  logic [31:0] mem_d [256];
  logic [31:0] shadow [256];

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_dram_port #(.DUAL_PORT(1'b0)) i_dma_dram_port (
    .clk(clk), .rst(rst), .dma_req_n(req_n), .dma_write(wr), .dma_addr(addr),
    .dma_size(size), .dma_wdata(wd), .dma_en(en), .dma_wait(dwait),
    .core_halted(halted), .dma_rdata(rd_s), .dma_ready(rdy_s), .core_stall(stl_s),
    .ram_addr(ra_s), .ram_en(ren_s), .ram_wdata(rwd_s), .ram_be(be_s), .ram_rdata(rrd_s));

  dma_dram_port #(.DUAL_PORT(1'b1)) i_dma_dram_port_dp (
    .clk(clk), .rst(rst), .dma_req_n(req_n), .dma_write(wr), .dma_addr(addr),
    .dma_size(size), .dma_wdata(wd), .dma_en(en), .dma_wait(dwait),
    .core_halted(1'b0), .dma_rdata(rd_d), .dma_ready(rdy_d), .core_stall(stl_d),
    .ram_addr(ra_d), .ram_en(ren_d), .ram_wdata(rwd_d), .ram_be(be_d), .ram_rdata(rrd_d));

  // Core model: halts one cycle after being asked to stall.
  always_ff @(posedge clk) halted <= rst ? 1'b0 : stl_s;

  // RAM models: synchronous read, byte-enabled write.
  always_ff @(posedge clk) begin
    if (ren_s) begin
      for (int l = 0; l < 4; l++) if (be_s[l]) mem_s[ra_s[7:0]][8*l +: 8] <= rwd_s[8*l +: 8];
      rrd_s <= mem_s[ra_s[7:0]];
    end
    if (ren_d) begin
      for (int l = 0; l < 4; l++) if (be_d[l]) mem_d[ra_d[7:0]][8*l +: 8] <= rwd_d[8*l +: 8];
      rrd_d <= mem_d[ra_d[7:0]];
    end
  end

  function automatic logic [3:0] exp_be(logic w, logic [1:0] s, logic [1:0] off);
    if (!w) return 4'b0000;
    case (s)
      2'b00:   return 4'b0001 << off;
      2'b01:   return off[1] ? 4'b1100 : 4'b0011;
      2'b10:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(logic [1:0] s, logic [31:0] d);
    case (s)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic        o_en_s, o_en_d;
  logic [3:0]  o_be_s, o_be_d;
  logic [31:0] o_wd_s, o_wd_d;
  logic [23:0] o_a_s;

  task automatic access(logic w, logic [25:0] a, logic [1:0] s, logic [31:0] d, logic e);
    @(negedge clk);
    req_n = 1'b0; wr = w; addr = a; size = s; wd = d; en = e;
    @(posedge clk);
    @(negedge clk);
    req_n = 1'b1; en = 1'b1;
    o_en_s = ren_s; o_be_s = be_s; o_wd_s = rwd_s; o_a_s = ra_s;
    o_en_d = ren_d; o_be_d = be_d; o_wd_d = rwd_d;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shadow_write(logic [25:0] a, logic [1:0] s, logic [31:0] d);
    logic [3:0]  m = exp_be(1'b1, s, a[1:0]);
    logic [31:0] v = exp_wd(s, d);
    for (int l = 0; l < 4; l++) if (m[l]) shadow[a[9:2]][8*l +: 8] = v[8*l +: 8];
  endtask

  task automatic read_check(logic [7:0] w, string req);
    access(1'b0, {16'h0, w, 2'b00}, 2'b11, 32'h0, 1'b1);
    check(o_en_s && o_be_s == 4'b0000, req, {27'h0, o_en_s, o_be_s}, 32'h10);
    check(rd_s == shadow[w], req, rd_s, shadow[w]);
    check(rd_d == shadow[w], req, rd_d, shadow[w]);
  endtask

  task automatic write_check(logic [25:0] a, logic [1:0] s, logic [31:0] d, string req);
    access(1'b1, a, s, d, 1'b1);
    if (s == 2'b11) begin
      check(!o_en_s && !o_en_d, req, {31'h0, o_en_s | o_en_d}, 32'h0);
    end else begin
      check(o_en_s && o_be_s == exp_be(1'b1, s, a[1:0]), req, {27'h0, o_en_s, o_be_s},
            {27'h1, exp_be(1'b1, s, a[1:0])});
      check(o_wd_s == exp_wd(s, d), req, o_wd_s, exp_wd(s, d));
      check(o_a_s == a[25:2] && o_be_d == o_be_s && o_wd_d == o_wd_s, req,
            {8'h0, o_a_s}, {8'h0, a[25:2]});
      shadow_write(a, s, d);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_s[i] = '0; mem_d[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!ren_s && be_s == 0 && !rdy_s && !stl_s && rd_s == 0, "R1", {ren_s, rdy_s, stl_s}, 0);
    check(!ren_d && !rdy_d && rd_d == 0, "R1", {ren_d, rdy_d}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!rdy_s && !stl_s, "R1", {rdy_s, stl_s}, 0);
    check(rdy_d && !stl_d, "R6", {rdy_d, stl_d}, 32'h2);

    // R5/R6: request before the stall handshake
    access(1'b0, 26'h14, 2'b10, 32'h0, 1'b1);
    check(!o_en_s, "R5", o_en_s, 0);
    check(o_en_d, "R6", o_en_d, 1);

    // R4: handshake timing
    dwait = 1'b1;
    @(negedge clk);
    check(stl_s && !rdy_s, "R4", {stl_s, rdy_s}, 32'h2);
    @(negedge clk);
    check(!rdy_s, "R4", rdy_s, 0);
    @(negedge clk);
    check(rdy_s, "R4", rdy_s, 1);
    check(!stl_d && rdy_d, "R6", {stl_d, rdy_d}, 32'h1);

    // R9/R2 word write, R11 read
    write_check({16'h0, 8'd3, 2'b00}, 2'b10, 32'h11223344, "R9");
    read_check(8'd3, "R11");
    // R7 each byte lane
    for (int o = 0; o < 4; o++)
      write_check({16'h0, 8'd4, 2'(o)}, 2'b00, 32'hA5 + o, "R7");
    read_check(8'd4, "R7");
    // R8 halfwords, odd address low bit ignored
    write_check({16'h0, 8'd5, 2'b01}, 2'b01, 32'hFFFFBEEF, "R8");
    write_check({16'h0, 8'd5, 2'b10}, 2'b01, 32'h0000CAFE, "R8");
    read_check(8'd5, "R8");
    // R10 reserved size
    write_check({16'h0, 8'd3, 2'b00}, 2'b11, 32'hDEADDEAD, "R10");
    read_check(8'd3, "R10");
    // R3 port disabled
    access(1'b1, {16'h0, 8'd3, 2'b00}, 2'b10, 32'h55555555, 1'b0);
    check(!o_en_s && !o_en_d, "R3", {o_en_s, o_en_d}, 0);
    read_check(8'd3, "R3");
    // R11 hold across a write
    write_check({16'h0, 8'd9, 2'b00}, 2'b10, 32'h99999999, "R11");
    check(rd_s == shadow[3], "R11", rd_s, shadow[3]);
    // R11 read ignores size
    access(1'b0, {16'h0, 8'd5, 2'b00}, 2'b00, 32'h0, 1'b1);
    check(rd_s == shadow[5], "R11", rd_s, shadow[5]);

    // Random mix
    void'($urandom(32'h5EED));
    for (int n = 0; n < 200; n++) begin
      logic [7:0]  w  = 8'($urandom % 32);
      logic [1:0]  o  = 2'($urandom);
      logic [1:0]  s  = 2'($urandom);
      logic [31:0] d  = $urandom;
      if ($urandom % 3 == 0) read_check(w, "R11");
      else write_check({16'h0, w, o}, s, d, s == 2'b11 ? "R10" : "R7");
    end

    // R4 release
    @(negedge clk);
    dwait = 1'b0;
    @(negedge clk);
    check(!stl_s && !rdy_s, "R4", {stl_s, rdy_s}, 0);
    check(rdy_d, "R6", rdy_d, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule